// File: doc/BRIEF.md
# SDI Transmit Rate-Adaptation FIFO

This block moves parallel video words from the source (pixel) clock domain into the serializer core clock domain of a serial digital video transmitter. It is a dual-clock FIFO with 20-bit words. The mode input selects one of two behaviours. In the high-definition mode the block only re-times the stream: it stores a word on every source clock and delivers a word on every core clock. In the standard-definition mode it also adapts the rate for the five-times oversampler that follows. Two consecutive 10-bit source words are packed into one stored word. On the read side a strobe fires once in every five core clocks, so the oversampler receives a fresh word once per five-cycle period.

Read and write positions cross between the two domains as Gray-coded pointers through multi-flop synchronizers. After a reset the read strobe stays low until the core domain sees at least two stored words. From then on it runs freely. If a write meets a full FIFO, the word is dropped and a sticky overflow flag is set. If a read meets an empty FIFO, the last output word is held and a sticky underflow flag is set. The mode input is static while either domain is out of reset.

Top module: `sdi_rate_fifo`

## Requirements
- R1: With `sd_mode`=0, the block stores the full 20-bit `src_data` on every `src_clk` rising edge. The words come out on `core_data` in the order they were written, with none lost or repeated, as long as no overflow occurs.
- R2: With `sd_mode`=0, once `core_tick` has risen after reset it stays high on every `core_clk` cycle.
- R3: With `sd_mode`=1, the block stores one word every second `src_clk` edge, counted from the first edge after `src_rst_n` is released. The first source word's `src_data[9:0]` goes into stored bits [9:0] and the second word's `src_data[9:0]` goes into bits [19:10]. `src_data[19:10]` is ignored.
- R4: With `sd_mode`=1, once `core_tick` has risen after reset it is high on exactly one core cycle in every five, so consecutive strobes are five core cycles apart.
- R5: After reset, `core_tick` stays low until the core domain has seen at least two stored words.
- R6: A `core_tick` while the FIFO is not empty pops the oldest word. That word appears on `core_data` one core cycle later, with `core_valid` high for that cycle. `core_valid` is never high otherwise.
- R7: `src_full` goes high once 16 unread words are stored. A write attempted while `src_full` is high is dropped, and `src_overflow` is set after that edge and stays set until reset.
- R8: A `core_tick` while `core_empty` is high leaves `core_data` unchanged and `core_valid` low. It sets `core_underflow`, which stays set until reset.
- R9: While in reset, `core_tick`, `core_valid`, `core_data`, `src_full`, `src_overflow` and `core_underflow` are 0 and `core_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source (pixel) clock |
| src_rst_n | input | 1 | Active-low reset, source domain |
| sd_mode | input | 1 | 1 = standard-definition packing and divide-by-five read, 0 = high-definition pass-through |
| src_data | input | 20 | Parallel video word; only bits [9:0] are used when `sd_mode`=1 |
| src_full | output | 1 | FIFO full, as seen from the source domain |
| src_overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| core_clk | input | 1 | Serializer core clock |
| core_rst_n | input | 1 | Active-low reset, core domain |
| core_tick | output | 1 | Read strobe to the oversampler |
| core_valid | output | 1 | `core_data` holds a freshly popped word this cycle |
| core_data | output | 20 | Word delivered to the oversampler |
| core_empty | output | 1 | FIFO empty, as seen from the core domain |
| core_underflow | output | 1 | Sticky: a strobe found the FIFO empty |

## Verification
A stored word reaches the core side only after its Gray pointer has passed the two-flop synchronizer, so its arrival time depends on the clock ratio. The scoreboard therefore compares words by order and not by cycle: each written word is queued, and each `core_valid` pops and compares one entry. Some results are due at fixed times. A popped word is due one core cycle after its strobe, and strobe spacing is checked cycle by cycle against one and five. `src_full` is due right after the 16th write edge and `src_overflow` right after the 17th. All outputs are sampled on the falling edge that follows the rising edge that updates them.

// File: rtl/sdi_rafifo_pkg.sv
package sdi_rafifo_pkg;

   typedef enum logic {
      SDI_MODE_HD = 1'b0,
      SDI_MODE_SD = 1'b1
   } sdi_mode_e;

   localparam int unsigned SDI_NARROW_W_DEF = 10;
   localparam int unsigned SDI_ADDR_W_DEF   = 4;
   localparam int unsigned SDI_SD_DIV_DEF   = 5;
   localparam int unsigned SDI_SYNC_DEF     = 2;
   localparam int unsigned SDI_ARM_FILL_DEF = 2;

endpackage

// File: rtl/sdi_rafifo_sync.sv
module sdi_rafifo_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sdi_rafifo_gptr.sv
module sdi_rafifo_gptr #(
   parameter int unsigned AW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   output logic [AW:0] bin,
   output logic [AW:0] gray
);

   logic [AW:0] bin_nx;

   assign bin_nx = bin + {{AW{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin  <= '0;
         gray <= '0;
      end else if (inc) begin
         bin  <= bin_nx;
         gray <= bin_nx ^ (bin_nx >> 1);
      end
   end

endmodule

// File: rtl/sdi_rafifo_pack.sv
module sdi_rafifo_pack
   import sdi_rafifo_pkg::*;
#(
   parameter int unsigned NW = 10,
   localparam int unsigned WW = 2 * NW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sdi_mode_e     mode,
   input  logic [WW-1:0] in_data,
   output logic          wr_req,
   output logic [WW-1:0] wr_word
);

   logic          odd_q;
   logic [NW-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_q <= 1'b0;
         low_q <= '0;
      end else if (mode == SDI_MODE_SD) begin
         odd_q <= ~odd_q;
         if (!odd_q) low_q <= in_data[NW-1:0];
      end
   end

   always_comb begin
      if (mode == SDI_MODE_SD) begin
         wr_req  = odd_q;
         wr_word = {in_data[NW-1:0], low_q};
      end else begin
         wr_req  = rst_n;
         wr_word = in_data;
      end
   end

endmodule

// File: rtl/sdi_rafifo_rdtick.sv
module sdi_rafifo_rdtick
   import sdi_rafifo_pkg::*;
#(
   parameter int unsigned DIV      = 5,
   parameter int unsigned AW       = 4,
   parameter int unsigned ARM_FILL = 2,
   localparam int unsigned CW      = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  sdi_mode_e   mode,
   input  logic [AW:0] fill,
   output logic        tick
);

   logic          armed_q;
   logic [CW-1:0] phase_q;
   logic          wrap;

   assign wrap = (phase_q == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         phase_q <= '0;
      end else begin
         if (fill >= (AW+1)'(ARM_FILL)) armed_q <= 1'b1;
         if (armed_q) phase_q <= wrap ? '0 : phase_q + 1'b1;
      end
   end

   always_comb begin
      if (mode == SDI_MODE_SD) tick = armed_q && (phase_q == '0);
      else                     tick = armed_q;
   end

endmodule

// File: rtl/sdi_rate_fifo.sv
module sdi_rate_fifo
   import sdi_rafifo_pkg::*;
#(
   parameter int unsigned NARROW_W    = SDI_NARROW_W_DEF,
   parameter int unsigned ADDR_W      = SDI_ADDR_W_DEF,
   parameter int unsigned SD_DIV      = SDI_SD_DIV_DEF,
   parameter int unsigned SYNC_STAGES = SDI_SYNC_DEF,
   parameter int unsigned ARM_FILL    = SDI_ARM_FILL_DEF,
   localparam int unsigned WORD_W     = 2 * NARROW_W
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic              sd_mode,
   input  logic [WORD_W-1:0] src_data,
   output logic              src_full,
   output logic              src_overflow,
   input  logic              core_clk,
   input  logic              core_rst_n,
   output logic              core_tick,
   output logic              core_valid,
   output logic [WORD_W-1:0] core_data,
   output logic              core_empty,
   output logic              core_underflow
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PW    = ADDR_W + 1;

   generate
      if (NARROW_W < 1) begin : g_bad_narrow
         $error("NARROW_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (SD_DIV < 2) begin : g_bad_div
         $error("SD_DIV must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ARM_FILL < 1 || ARM_FILL > DEPTH) begin : g_bad_arm
         $error("ARM_FILL must lie between 1 and the depth");
      end
   endgenerate

   function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   sdi_mode_e mode;
   assign mode = sdi_mode_e'(sd_mode);

   // ---------------- source domain ----------------
   logic              src_wr_req;
   logic [WORD_W-1:0] src_wr_word;
   logic              src_wr_do;
   logic [PW-1:0]     wr_bin, wr_gray;
   logic [PW-1:0]     rd_gray_at_src;
   logic              ovf_q;
   logic [WORD_W-1:0] mem [DEPTH];

   sdi_rafifo_pack #(.NW(NARROW_W)) u_pack (
      .clk     (src_clk),
      .rst_n   (src_rst_n),
      .mode    (mode),
      .in_data (src_data),
      .wr_req  (src_wr_req),
      .wr_word (src_wr_word)
   );

   assign src_full  = (wr_gray == {~rd_gray_at_src[PW-1:PW-2], rd_gray_at_src[PW-3:0]});
   assign src_wr_do = src_wr_req && !src_full;

   sdi_rafifo_gptr #(.AW(ADDR_W)) u_wptr (
      .clk   (src_clk),
      .rst_n (src_rst_n),
      .inc   (src_wr_do),
      .bin   (wr_bin),
      .gray  (wr_gray)
   );

   always_ff @(posedge src_clk) begin
      if (src_wr_do) mem[wr_bin[ADDR_W-1:0]] <= src_wr_word;
   end

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)                   ovf_q <= 1'b0;
      else if (src_wr_req && src_full)  ovf_q <= 1'b1;
   end
   assign src_overflow = ovf_q;

   sdi_rafifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk   (src_clk),
      .rst_n (src_rst_n),
      .d     (rd_gray),
      .q     (rd_gray_at_src)
   );

   // ---------------- core domain ----------------
   logic [PW-1:0]     rd_bin, rd_gray;
   logic [PW-1:0]     wr_gray_at_core;
   logic [PW-1:0]     core_fill;
   logic              core_pop;
   logic              valid_q, udf_q;
   logic [WORD_W-1:0] data_q;

   sdi_rafifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk   (core_clk),
      .rst_n (core_rst_n),
      .d     (wr_gray),
      .q     (wr_gray_at_core)
   );

   assign core_empty = (rd_gray == wr_gray_at_core);
   assign core_fill  = gray_to_bin(wr_gray_at_core) - rd_bin;

   sdi_rafifo_rdtick #(.DIV(SD_DIV), .AW(ADDR_W), .ARM_FILL(ARM_FILL)) u_tick (
      .clk   (core_clk),
      .rst_n (core_rst_n),
      .mode  (mode),
      .fill  (core_fill),
      .tick  (core_tick)
   );

   assign core_pop = core_tick && !core_empty;

   sdi_rafifo_gptr #(.AW(ADDR_W)) u_rptr (
      .clk   (core_clk),
      .rst_n (core_rst_n),
      .inc   (core_pop),
      .bin   (rd_bin),
      .gray  (rd_gray)
   );

   always_ff @(posedge core_clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         udf_q   <= 1'b0;
      end else begin
         valid_q <= core_pop;
         if (core_pop)                 data_q <= mem[rd_bin[ADDR_W-1:0]];
         if (core_tick && core_empty)  udf_q  <= 1'b1;
      end
   end

   assign core_valid     = valid_q;
   assign core_data      = data_q;
   assign core_underflow = udf_q;

endmodule

// File: rtl/sdi_rate_fifo_chk.sv
module sdi_rate_fifo_chk #(
   parameter int unsigned WORD_W = 20
) (
   input logic              src_clk,
   input logic              src_rst_n,
   input logic              core_clk,
   input logic              core_rst_n,
   input logic              sd_mode,
   input logic              src_wr_req,
   input logic              src_full,
   input logic              src_overflow,
   input logic              core_tick,
   input logic              core_empty,
   input logic              core_valid,
   input logic [WORD_W-1:0] core_data,
   input logic              core_underflow
);

   p_overflow_set_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_wr_req && src_full) |=> src_overflow);

   p_overflow_sticky_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      src_overflow |=> src_overflow);

   p_sd_write_alt_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (sd_mode && src_wr_req) |=> !src_wr_req);

   p_underflow_set_r8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (core_tick && core_empty) |=> core_underflow);

   p_underflow_sticky_r8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      core_underflow |=> core_underflow);

   p_hold_on_empty_r8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (core_tick && core_empty) |=> (!core_valid && $stable(core_data)));

   p_valid_after_pop_r6: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (core_tick && !core_empty) |=> core_valid);

   p_valid_needs_tick_r6: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      core_valid |-> $past(core_tick && !core_empty));

   p_sd_gap_r4: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (sd_mode && core_tick) |=> !core_tick);

   p_hd_tick_hold_r2: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (!sd_mode && core_tick) |=> core_tick);

endmodule

bind sdi_rate_fifo sdi_rate_fifo_chk #(.WORD_W(WORD_W)) i_chk (
   .src_clk        (src_clk),
   .src_rst_n      (src_rst_n),
   .core_clk       (core_clk),
   .core_rst_n     (core_rst_n),
   .sd_mode        (sd_mode),
   .src_wr_req     (src_wr_req),
   .src_full       (src_full),
   .src_overflow   (src_overflow),
   .core_tick      (core_tick),
   .core_empty     (core_empty),
   .core_valid     (core_valid),
   .core_data      (core_data),
   .core_underflow (core_underflow)
);

// File: tb/test_sdi_rate_fifo.sv
`timescale 1ns/1ps
module test_sdi_rate_fifo;

   logic        src_clk = 1'b0;
   logic        core_clk = 1'b0;
   logic        src_rst_n = 1'b0;
   logic        core_rst_n = 1'b0;
   logic        sd_mode = 1'b0;
   logic [19:0] src_data = '0;
   logic        src_full, src_overflow;
   logic        core_tick, core_valid, core_empty, core_underflow;
   logic [19:0] core_data;

   real core_half = 4.0;

   always #5 src_clk = ~src_clk;
   always #(core_half) core_clk = ~core_clk;

   sdi_rate_fifo i_sdi_rate_fifo (
      .src_clk        (src_clk),
      .src_rst_n      (src_rst_n),
      .sd_mode        (sd_mode),
      .src_data       (src_data),
      .src_full       (src_full),
      .src_overflow   (src_overflow),
      .core_clk       (core_clk),
      .core_rst_n     (core_rst_n),
      .core_tick      (core_tick),
      .core_valid     (core_valid),
      .core_data      (core_data),
      .core_empty     (core_empty),
      .core_underflow (core_underflow)
   );

   int          total = 0;
   int          bad = 0;
   logic [19:0] exp_q[$];
   bit          mon_en = 0;
   bit          seen_tick = 0;
   int          gap = 0;
   int          pre_ticks = 0;
   int          words = 0;
   int          compared = 0;
   bit          half = 0;
   logic [9:0]  low_word = '0;
   logic [19:0] last_data = '0;
   int          wd_cycles = 0;

   task automatic report_fail(input string req, input logic [31:0] act, input logic [31:0] exp);
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) report_fail(req, act, exp);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // watchdog
   always @(posedge src_clk) begin
      wd_cycles++;
      if (wd_cycles > 150000) begin
         total++;
         report_fail("watchdog", wd_cycles, 150000);
         finish_run();
      end
   end

   // monitor: pops expected words and checks strobe behaviour
   always @(negedge core_clk) begin
      if (mon_en && core_rst_n) begin
         if (!src_rst_n && core_tick) pre_ticks++;
         if (core_valid) begin
            total++;
            if (exp_q.size() == 0) report_fail("R1/R3 unexpected word", core_data, 0);
            else begin
               logic [19:0] e;
               e = exp_q.pop_front();
               compared++;
               if (core_data !== e) report_fail(sd_mode ? "R3 packed word" : "R1 word order", core_data, e);
            end
         end else begin
            total++;
            if (core_data !== last_data) report_fail("R8 data held", core_data, last_data);
         end
         if (core_tick) begin
            if (!seen_tick) begin
               seen_tick = 1;
               total++;
               if (words < 2) report_fail("R5 strobe before two words", words, 2);
            end else if (sd_mode) begin
               check("R4 strobe spacing", gap, 5);
            end
            gap = 1;
         end else begin
            gap++;
            if (seen_tick && !sd_mode) report_fail("R2 strobe dropped", 0, 1);
         end
         if (seen_tick && !sd_mode) total++;
      end
      last_data = core_data;
   end

   task automatic apply_reset();
      mon_en = 0;
      src_rst_n = 0;
      core_rst_n = 0;
      repeat (5) @(negedge src_clk);
      exp_q.delete();
      seen_tick = 0;
      gap = 0;
      pre_ticks = 0;
      words = 0;
      compared = 0;
      half = 0;
   endtask

   // driver: drive before each source edge, then queue the expected stored word
   task automatic run_traffic(input int n);
      for (int i = 0; i < n; i++) begin
         if (sd_mode) begin
            logic [9:0] nw;
            nw = 10'($urandom);
            src_data = {10'($urandom), nw};
            if (!half) begin
               low_word = nw;
               half = 1;
            end else begin
               exp_q.push_back({nw, low_word});
               words++;
               half = 0;
            end
         end else begin
            src_data = 20'($urandom);
            exp_q.push_back(src_data);
            words++;
         end
         @(negedge src_clk);
      end
   endtask

   initial begin
      // T1: reset state (R9)
      apply_reset();
      check("R9 core_tick", core_tick, 0);
      check("R9 core_valid", core_valid, 0);
      check("R9 core_data", core_data, 0);
      check("R9 core_empty", core_empty, 1);
      check("R9 src_full", src_full, 0);
      check("R9 src_overflow", src_overflow, 0);
      check("R9 core_underflow", core_underflow, 0);

      // T2: HD mode, core slightly faster than source
      core_half = 4.0;
      sd_mode = 0;
      apply_reset();
      @(negedge core_clk);
      core_rst_n = 1;
      mon_en = 1;
      repeat (40) @(negedge src_clk);
      check("R5 no strobe while nothing stored", pre_ticks, 0);
      src_rst_n = 1;
      run_traffic(400);
      mon_en = 0;
      check("R1 words compared", compared > 300, 1);
      check("R2 strobe armed in HD", seen_tick, 1);
      check("R8 underflow flagged", core_underflow, 1);
      check("R7 no overflow", src_overflow, 0);

      // T3: SD mode, read strobe every fifth core cycle
      core_half = 1.5;
      sd_mode = 1;
      apply_reset();
      @(negedge core_clk);
      core_rst_n = 1;
      mon_en = 1;
      @(negedge src_clk);
      src_rst_n = 1;
      run_traffic(400);
      mon_en = 0;
      check("R3 packed words compared", compared > 150, 1);
      check("R4 strobe armed in SD", seen_tick, 1);
      check("R7 no overflow in SD", src_overflow, 0);

      // T4: HD overflow with the core side held in reset
      core_half = 4.0;
      sd_mode = 0;
      apply_reset();
      src_rst_n = 1;
      run_traffic(15);
      check("R7 not full at 15", src_full, 0);
      check("R7 no overflow at 15", src_overflow, 0);
      run_traffic(1);
      check("R7 full at 16", src_full, 1);
      check("R7 no overflow at 16", src_overflow, 0);
      run_traffic(1);
      check("R7 overflow on 17th", src_overflow, 1);
      run_traffic(6);
      check("R7 overflow sticky", src_overflow, 1);
      check("R7 still full", src_full, 1);
      check("R9 core idle in reset", core_valid, 0);
      check("R9 core empty in reset", core_empty, 1);

      // T5: reset clears the sticky flags
      apply_reset();
      check("R9 overflow cleared", src_overflow, 0);
      check("R9 underflow cleared", core_underflow, 0);
      check("R9 full cleared", src_full, 0);

      finish_run();
   end

endmodule